// File: doc/BRIEF.md
# Idle Packet-End Timeout Timer

This block sits beside the outbound side of a USB slave-FIFO bridge. It watches the bridge's internal transmit FIFO and the endpoint buffer of the USB controller. It measures how long outbound traffic has been stalled. The stall timer runs while the transmit FIFO has nothing left to send and the selected endpoint still holds bytes that have not been committed. When the timer reaches a programmed cycle count, the block raises a single-cycle packet-end request. That request makes the controller ship the partial buffer as a short packet, so the host receives data below the 512-byte packet size without waiting for a full packet.

Selecting the receive endpoint clears the timer. So does any break in the stall condition. A timeout of zero turns the feature off. After the block has asked for a packet end, it stays quiet until fresh data is written to the endpoint, so an empty packet is never committed twice. Requests are withheld while a write strobe is on the bus. The block only issues the request; driving the bus pins belongs to the surrounding bridge.

Top module: `idle_pktend_timer`

## Requirements
- R1: After reset `pktEndReq` is 0 and the block is disarmed. A stall that follows reset, with no write strobe seen since reset, produces no request.
- R2: The timer advances only in a cycle where `txFifoEmpty`=1, `epEmpty`=0, `rxEpSel`=0 and `wrStrobe`=0, the block is armed and `timeoutCycles` is nonzero. A timer that is not advancing restarts from zero.
- R3: With `timeoutCycles`=T>0, the T-th consecutive qualifying cycle causes `pktEndReq` to be 1 in the following cycle, for exactly one cycle.
- R4: A cycle with `rxEpSel`=1 clears the timer, so a fresh run of T qualifying cycles is needed.
- R5: A cycle with `txFifoEmpty`=0 or `epEmpty`=1 clears the timer.
- R6: `timeoutCycles`=0 disables the block: no request is ever issued.
- R7: After a request the block is disarmed. No further request occurs until a cycle with `wrStrobe`=1 re-arms it.
- R8: A cycle with `wrStrobe`=1 arms the block, clears the timer and produces no request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timeoutCycles | input | CNT_W | Programmed idle cycles before a request (0 = off) |
| txFifoEmpty | input | 1 | Internal transmit FIFO has no words |
| epEmpty | input | 1 | Current USB endpoint buffer is empty |
| rxEpSel | input | 1 | Controller has the receive endpoint selected |
| wrStrobe | input | 1 | A byte is being written to the endpoint this cycle |
| pktEndReq | output | 1 | One-cycle packet-end request |

## Verification
The assertions assume that `timeoutCycles` changes only while the timer is cleared or disabled, so the counter never sits above the limit. The assertions also assume that all inputs are synchronous to `clk`. The stimulus changes the timeout only in cycles that carry a write strobe or a zero timeout. The stimulus drives every input one time unit after the rising edge.

// File: rtl/idle_pktend_pkg.sv
package idle_pktend_pkg;
  typedef struct packed {
    logic clear;
    logic inc;
  } tmrCtl_t;
endpackage

// File: rtl/idle_pktend_dp.sv
module idle_pktend_dp
  import idle_pktend_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] timeoutCycles,
  input  tmrCtl_t          ctl,
  output logic             atLimit,
  output logic             timeoutZero
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] idleCnt;
  logic [EXT_W-1:0] nextCnt;

  assign nextCnt     = {1'b0, idleCnt} + EXT_W'(1);
  assign atLimit     = nextCnt >= {1'b0, timeoutCycles};
  assign timeoutZero = (timeoutCycles == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          idleCnt <= '0;
    else if (ctl.clear) idleCnt <= '0;
    else if (ctl.inc)   idleCnt <= nextCnt[CNT_W-1:0];
  end

  // R2/R4/R5: a clear strobe leaves the timer at zero
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> idleCnt == '0);
  // R2: an advance steps by exactly one
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.inc && !ctl.clear) |=> idleCnt == $past(idleCnt) + CNT_W'(1));
  // R2: the control side never asks to clear and advance at once
  a_r2_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.clear && ctl.inc));
endmodule

// File: rtl/idle_pktend_ctl.sv
module idle_pktend_ctl
  import idle_pktend_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    txFifoEmpty,
  input  logic    epEmpty,
  input  logic    rxEpSel,
  input  logic    wrStrobe,
  input  logic    atLimit,
  input  logic    timeoutZero,
  output tmrCtl_t ctl,
  output logic    pktEndReq
);
  logic armed;
  logic stalled;
  logic fire;

  assign stalled = txFifoEmpty && !epEmpty && !rxEpSel && !wrStrobe
                   && armed && !timeoutZero;
  assign fire    = stalled && atLimit;

  always_comb begin
    ctl.clear = !stalled || fire;
    ctl.inc   = stalled && !atLimit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      pktEndReq <= 1'b0;
    end else begin
      pktEndReq <= fire;
      if (wrStrobe)  armed <= 1'b1;
      else if (fire) armed <= 1'b0;
    end
  end

  // R3: the request lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pktEndReq |=> !pktEndReq);
  // R2: a request follows a genuine stall cycle
  a_r2_stall_cause: assert property (@(posedge clk) disable iff (!rstN)
    pktEndReq |-> $past(txFifoEmpty && !epEmpty && !rxEpSel && !wrStrobe));
  // R4: receive endpoint selection blocks a request
  a_r4_rx_block: assert property (@(posedge clk) disable iff (!rstN)
    rxEpSel |=> !pktEndReq);
  // R6: zero timeout blocks a request
  a_r6_disabled: assert property (@(posedge clk) disable iff (!rstN)
    timeoutZero |=> !pktEndReq);
  // R8: a write strobe blocks a request
  a_r8_wr_block: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !pktEndReq);
endmodule

// File: rtl/idle_pktend_timer.sv
module idle_pktend_timer
  import idle_pktend_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] timeoutCycles,
  input  logic             txFifoEmpty,
  input  logic             epEmpty,
  input  logic             rxEpSel,
  input  logic             wrStrobe,
  output logic             pktEndReq
);
  tmrCtl_t ctl;
  logic    atLimit;
  logic    timeoutZero;

  idle_pktend_dp #(.CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .timeoutCycles(timeoutCycles),
    .ctl          (ctl),
    .atLimit      (atLimit),
    .timeoutZero  (timeoutZero)
  );

  idle_pktend_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .txFifoEmpty(txFifoEmpty),
    .epEmpty    (epEmpty),
    .rxEpSel    (rxEpSel),
    .wrStrobe   (wrStrobe),
    .atLimit    (atLimit),
    .timeoutZero(timeoutZero),
    .ctl        (ctl),
    .pktEndReq  (pktEndReq)
  );
endmodule

// File: tb/sim_idle_pktend_timer.sv
`timescale 1ns/1ps
module sim_idle_pktend_timer;
  localparam int CNT_W = 16;
  localparam int NVEC  = 29;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] timeoutCycles = '0;
  logic txFifoEmpty = 1'b1, epEmpty = 1'b1, rxEpSel = 1'b0, wrStrobe = 1'b0;
  logic pktEndReq;
  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  idle_pktend_timer #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .timeoutCycles(timeoutCycles),
    .txFifoEmpty(txFifoEmpty), .epEmpty(epEmpty), .rxEpSel(rxEpSel),
    .wrStrobe(wrStrobe), .pktEndReq(pktEndReq)
  );

  // The fields are timeout[16:9], txEmpty[8], epEmpty[7], rxSel[6], wr[5], expected[4], and requirement tag[3:0].
  localparam logic [16:0] VEC [NVEC] = '{
    {8'd3, 5'b01000, 4'd1}, // R1 idle, disarmed
    {8'd3, 5'b00010, 4'd8}, // R8 write arms
    {8'd3, 5'b10000, 4'd2}, // R2 count 1
    {8'd3, 5'b10000, 4'd2}, // R2 count 2
    {8'd3, 5'b10001, 4'd3}, // R3 third cycle fires
    {8'd3, 5'b10000, 4'd7}, // R7 disarmed
    {8'd3, 5'b10000, 4'd7}, // R7 disarmed
    {8'd3, 5'b00010, 4'd8}, // R8 rearm
    {8'd3, 5'b10000, 4'd2},
    {8'd3, 5'b10000, 4'd2},
    {8'd3, 5'b10100, 4'd4}, // R4 rx select clears
    {8'd3, 5'b10000, 4'd4},
    {8'd3, 5'b10000, 4'd4},
    {8'd3, 5'b00000, 4'd5}, // R5 tx not empty clears
    {8'd3, 5'b10000, 4'd5},
    {8'd3, 5'b10000, 4'd5},
    {8'd3, 5'b11000, 4'd5}, // R5 endpoint empty clears
    {8'd3, 5'b10000, 4'd5},
    {8'd3, 5'b10000, 4'd5},
    {8'd3, 5'b10010, 4'd8}, // R8 write clears and suppresses
    {8'd3, 5'b10000, 4'd8},
    {8'd3, 5'b10000, 4'd8},
    {8'd3, 5'b10001, 4'd3}, // R3 fires after full run
    {8'd0, 5'b00010, 4'd6}, // R6 rearm with timeout 0
    {8'd0, 5'b10000, 4'd6},
    {8'd0, 5'b10000, 4'd6},
    {8'd0, 5'b10000, 4'd6},
    {8'd0, 5'b10000, 4'd6},
    {8'd1, 5'b10001, 4'd3}  // R3 timeout 1 fires on first cycle
  };

  task automatic check(input logic exp, input int tag, input string what);
    total++;
    if (pktEndReq !== exp) begin
      bad++;
      $display("FAIL R%0d %s: pktEndReq=%0b expected=%0b", tag, what, pktEndReq, exp);
    end
  endtask

  task automatic drive(input int to, input logic tx, input logic ep,
                       input logic rx, input logic wr);
    timeoutCycles = CNT_W'(to);
    txFifoEmpty = tx; epEmpty = ep; rxEpSel = rx; wrStrobe = wr;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(1'b0, 1, "output during reset");   // R1
    rstN = 1'b1;
    @(posedge clk); #1;
    check(1'b0, 1, "output after reset");    // R1

    for (int i = 0; i < NVEC; i++) begin
      drive(int'(VEC[i][16:9]), VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5]);
      check(VEC[i][4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
    end

    // R3: a long timeout fires exactly on run 200
    drive(200, 1'b0, 1'b0, 1'b0, 1'b1);
    begin
      int early = 0;
      for (int k = 1; k < 200; k++) begin
        drive(200, 1'b1, 1'b0, 1'b0, 1'b0);
        if (pktEndReq !== 1'b0) early++;
      end
      total++;
      if (early != 0) begin
        bad++;
        $display("FAIL R3 long timeout early pulses=%0d expected=0", early);
      end
    end
    drive(200, 1'b1, 1'b0, 1'b0, 1'b0);
    check(1'b1, 3, "long timeout fire");
    drive(200, 1'b1, 1'b0, 1'b0, 1'b0);
    check(1'b0, 3, "pulse one cycle wide");

    // R1: reset mid-run disarms the block
    drive(3, 1'b0, 1'b0, 1'b0, 1'b1);
    drive(3, 1'b1, 1'b0, 1'b0, 1'b0);
    drive(3, 1'b1, 1'b0, 1'b0, 1'b0);
    rstN = 1'b0;
    @(posedge clk); #1;
    rstN = 1'b1;
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin
        drive(3, 1'b1, 1'b0, 1'b0, 1'b0);
        if (pktEndReq !== 1'b0) seen++;
      end
      total++;
      if (seen != 0) begin
        bad++;
        $display("FAIL R1 stall after reset pulses=%0d expected=0", seen);
      end
    end
    // R7: after rearm following reset, it fires again
    drive(2, 1'b0, 1'b0, 1'b0, 1'b1);
    drive(2, 1'b1, 1'b0, 1'b0, 1'b0);
    check(1'b0, 7, "rearmed count 1");
    drive(2, 1'b1, 1'b0, 1'b0, 1'b0);
    check(1'b1, 7, "rearmed fire");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule